// File: doc/BRIEF.md
# Serial-Loaded Four-Group PWM Dimmer

This block takes dimming levels for four channel groups over a three-wire serial link and produces one PWM dimming output for each group. The three wires are a data line, a bit clock and an end-of-frame strobe. All three are asynchronous to the system clock, so the block synchronizes them before it uses them. Data bits shift into a holding buffer. The active duties change only when the end-of-frame strobe commits a complete 32-bit frame.

A free-running 8-bit counter defines a PWM period of 256 system clocks. Each group output is high for as many counts of that period as its code. Any non-zero code smaller than 2 is raised to 2. A committed frame waits for the next counter wrap before it takes effect, so no output ever carries a shortened or stretched pulse. Each output is shared by every channel in its group. Spreading an output to individual channel pins happens outside the block.

Top module: `quad_pwm_dimmer`

## Requirements
- R1: A data bit is sampled only on a rising edge of `ser_clk_i`, after a two-flop synchronizer. A change on `ser_data_i` while the bit clock is steady has no effect.
- R2: Within each byte the first bit received is bit 0 (least significant) and the eighth bit received is bit 7.
- R3: Of the four bytes in a frame, the first byte received drives `dim_o[3]`, the second drives `dim_o[2]`, the third drives `dim_o[1]` and the fourth drives `dim_o[0]`.
- R4: A falling edge on `ser_eof_i` commits all four buffered bytes together. Until that edge, the outputs keep their previous duties, even after a full 32 bits have been shifted in.
- R5: The bit count returns to zero on every end-of-frame falling edge. A frame whose bit count is not exactly 32 is discarded and leaves the duties unchanged.
- R6: A group with code N (N ≥ 2) is high for exactly N of every 256 system clocks. Code 0 keeps the output low, and code 255 gives 255 high clocks.
- R7: Code 1 gives the same 2 high clocks per period as code 2. Any non-zero code is therefore high during the first two counts of the period.
- R8: The PWM period is 256 system clocks, counted by a free-running counter that steps by one each clock and wraps from 255 to 0.
- R9: A newly committed duty takes effect only at a counter wrap. Every complete high pulse therefore has either the old length or the new length.
- R10: While reset is held, and after it is released, all outputs are low and every group code is 0 until the first valid frame is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also sets the PWM period |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data line, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous; a rising edge samples data |
| ser_eof_i | input | 1 | End-of-frame strobe, idle high; a falling edge commits the frame |
| dim_o | output | 4 | Registered PWM outputs, bit 0 = last byte of the frame, bit 3 = first byte |

## Verification
The bench sends frames whose four bytes all differ and are not bit-symmetric (0x03, 0xC0, 0x0E, 0x70). A reversed bit order or a swapped byte order would therefore show up as a wrong duty on a specific output. A frame of codes 1, 2, 0 and 255 separates the floor rule from plain proportional duty at both ends of the code range.

Frames of 31 and 33 bits, and a full frame left uncommitted, show that only an exact frame followed by its strobe changes anything. Data that flips while the bit clock is high shows that sampling happens on the edge only. Run lengths of the high pulses, recorded across a duty change, separate an update at the counter wrap from an update partway through a period.

// File: rtl/dim_pkg.sv
package dim_pkg;

  // Smallest on-count that any non-zero code produces
  localparam int unsigned MIN_ON_COUNT = 2;

  // Raise a non-zero code below the floor up to the floor
  function automatic logic [15:0] floor_code(input logic [15:0] code,
                                             input int unsigned floor_v);
    if (code != 16'd0 && code < floor_v[15:0])
      return floor_v[15:0];
    return code;
  endfunction

endpackage

// File: rtl/dim_sync.sv
module dim_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/dim_frame_rx.sv
module dim_frame_rx #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned GROUPS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_stb_i,
  input  logic                     bit_val_i,
  input  logic                     eof_stb_i,
  output logic                     commit_o,
  output logic [GROUPS*CODE_W-1:0] codes_o
);

  localparam int unsigned FRAME_BITS = CODE_W * GROUPS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER  = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  commit_q;

  // Bits enter at the top and move down, so the first bit ends at bit 0.
  // The first byte received lands in the lowest slice (highest group index).
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      frame_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (eof_stb_i) begin
        cnt_q <= '0;
        if (cnt_q == FULL) begin
          frame_q  <= shift_q;
          commit_q <= 1'b1;
        end
      end else if (bit_stb_i) begin
        shift_q <= {bit_val_i, shift_q[FRAME_BITS-1:1]};
        if (cnt_q != OVER)
          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Group g takes the slice counted from the top: last byte -> group 0
  for (genvar g = 0; g < GROUPS; g++) begin : g_map
    assign codes_o[g*CODE_W +: CODE_W] = frame_q[(GROUPS-1-g)*CODE_W +: CODE_W];
  end

  assign commit_o = commit_q;

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eof_stb_i |=> cnt_q == '0);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= OVER);

  // R4
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> $past(eof_stb_i));

endmodule

// File: rtl/dim_pwm.sv
module dim_pwm
  import dim_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned GROUPS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [GROUPS*CODE_W-1:0] codes_i,
  output logic [GROUPS-1:0]        pwm_o
);

  localparam logic [CODE_W-1:0] LAST = '1;

  logic [CODE_W-1:0]        ctr_q;
  logic [GROUPS*CODE_W-1:0] pend_q;
  logic                     pend_v_q;
  logic [GROUPS*CODE_W-1:0] act_q;
  logic [GROUPS-1:0]        out_q;
  logic [GROUPS*CODE_W-1:0] eff;
  logic                     wrap;

  assign wrap = (ctr_q == LAST);

  for (genvar g = 0; g < GROUPS; g++) begin : g_eff
    logic [15:0] fl;
    assign fl = floor_code(16'(act_q[g*CODE_W +: CODE_W]), MIN_ON_COUNT);
    assign eff[g*CODE_W +: CODE_W] = fl[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= '0;
    end else begin
      ctr_q <= ctr_q + 1'b1;
      if (load_i)
        pend_q <= codes_i;
      if (wrap && pend_v_q) begin
        act_q    <= pend_q;
        pend_v_q <= load_i;
      end else if (load_i) begin
        pend_v_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_q[g] <= 1'b0;
      else     out_q[g] <= (ctr_q < eff[g*CODE_W +: CODE_W]);
    end

    // R6
    zero_low_chk: assert property (@(posedge clk) disable iff (rst)
      $past(act_q[g*CODE_W +: CODE_W]) == '0 |-> !out_q[g]);

    // R7
    floor_high_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(act_q[g*CODE_W +: CODE_W]) != '0 && $past(ctr_q) < CODE_W'(MIN_ON_COUNT))
        |-> out_q[g]);
  end

  assign pwm_o = out_q;

  // R8
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctr_q == $past(ctr_q) + 1'b1);

  // R9
  act_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> ctr_q == '0);

endmodule

// File: rtl/quad_pwm_dimmer.sv
module quad_pwm_dimmer #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned GROUPS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              ser_eof_i,
  output logic [GROUPS-1:0] dim_o
);

  logic data_lvl, data_rise, data_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic eof_lvl,  eof_rise,  eof_fall;
  logic                     commit;
  logic [GROUPS*CODE_W-1:0] codes;

  dim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_data (
    .clk(clk), .rst(rst), .async_i(ser_data_i),
    .level_o(data_lvl), .rise_o(data_rise), .fall_o(data_fall));

  dim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst(rst), .async_i(ser_clk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));

  dim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_eof (
    .clk(clk), .rst(rst), .async_i(ser_eof_i),
    .level_o(eof_lvl), .rise_o(eof_rise), .fall_o(eof_fall));

  dim_frame_rx #(.CODE_W(CODE_W), .GROUPS(GROUPS)) u_rx (
    .clk(clk), .rst(rst),
    .bit_stb_i(sclk_rise), .bit_val_i(data_lvl), .eof_stb_i(eof_fall),
    .commit_o(commit), .codes_o(codes));

  dim_pwm #(.CODE_W(CODE_W), .GROUPS(GROUPS)) u_pwm (
    .clk(clk), .rst(rst), .load_i(commit), .codes_i(codes), .pwm_o(dim_o));

  // R10
  rst_low_chk: assert property (@(posedge clk)
    $past(rst) |-> dim_o == '0);

endmodule

// File: tb/quad_pwm_dimmer_test.sv
module quad_pwm_dimmer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sdat = 1'b0;
  logic       sclk = 1'b0;
  logic       seof = 1'b1;
  logic [3:0] dim;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quad_pwm_dimmer uut (
    .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk),
    .ser_eof_i(seof), .dim_o(dim));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // w[0] goes first; scramble flips data while the bit clock is high
  task automatic send_bits(input logic [63:0] w, input int n, input bit scramble);
    for (int i = 0; i < n; i++) begin
      sdat = w[i];
      tick(3);
      sclk = 1'b1;
      tick(4);
      if (scramble) sdat = ~w[i];
      tick(3);
      sclk = 1'b0;
      tick(2);
    end
  endtask

  task automatic pulse_eof();
    seof = 1'b0;
    tick(4);
    seof = 1'b1;
    tick(4);
  endtask

  // Frame word: first byte (group 3) in bits 7:0, last byte (group 0) in 31:24
  function automatic logic [63:0] frame(input logic [7:0] g0, input logic [7:0] g1,
                                        input logic [7:0] g2, input logic [7:0] g3);
    return {32'h0, g0, g1, g2, g3};
  endfunction

  task automatic expect_duty(input int e0, input int e1, input int e2, input int e3,
                             input string tag);
    int hi [4];
    for (int g = 0; g < 4; g++) hi[g] = 0;
    tick(600);
    for (int c = 0; c < 256; c++) begin
      for (int g = 0; g < 4; g++) if (dim[g]) hi[g]++;
      tick(1);
    end
    chk(hi[0], e0, {tag, " grp0"});
    chk(hi[1], e1, {tag, " grp1"});
    chk(hi[2], e2, {tag, " grp2"});
    chk(hi[3], e3, {tag, " grp3"});
  endtask

  task automatic t_reset();
    chk(int'(dim), 0, "R10 outputs low at reset");
    rst = 1'b0;
    tick(2);
    chk(int'(dim), 0, "R10 outputs low after release");
    expect_duty(0, 0, 0, 0, "R10 idle duty");
  endtask

  task automatic t_order();
    send_bits(frame(8'h80, 8'h40, 8'h10, 8'hFF), 32, 1'b0);
    pulse_eof();
    expect_duty(128, 64, 16, 255, "R3 R6 byte to group");
    send_bits(frame(8'h03, 8'hC0, 8'h0E, 8'h70), 32, 1'b0);
    pulse_eof();
    expect_duty(3, 192, 14, 112, "R2 lsb first");
  endtask

  task automatic t_floor();
    send_bits(frame(8'h01, 8'h02, 8'h00, 8'hFF), 32, 1'b0);
    pulse_eof();
    expect_duty(2, 2, 0, 255, "R7 R6 floor and ends");
  endtask

  task automatic t_edge();
    send_bits(frame(8'h21, 8'h52, 8'h84, 8'h0B), 32, 1'b1);
    pulse_eof();
    expect_duty(33, 82, 132, 11, "R1 sample on rising edge");
  endtask

  task automatic t_hold();
    send_bits(frame(8'h20, 8'h30, 8'h40, 8'h50), 32, 1'b0);
    expect_duty(33, 82, 132, 11, "R4 hold without strobe");
    pulse_eof();
    expect_duty(32, 48, 64, 80, "R4 commit all groups");
  endtask

  task automatic t_badlen();
    send_bits(frame(8'h11, 8'h11, 8'h11, 8'h11), 31, 1'b0);
    pulse_eof();
    expect_duty(32, 48, 64, 80, "R5 short frame dropped");
    send_bits({31'h0, 1'b1, frame(8'h22, 8'h22, 8'h22, 8'h22)}, 33, 1'b0);
    pulse_eof();
    expect_duty(32, 48, 64, 80, "R5 long frame dropped");
    send_bits(frame(8'h80, 8'h09, 8'hA0, 8'hFE), 32, 1'b0);
    pulse_eof();
    expect_duty(128, 9, 160, 254, "R5 count restarts");
  endtask

  task automatic t_period();
    int gap;
    int run;
    while (dim[0]) tick(1);
    while (!dim[0]) tick(1);
    run = 0;
    while (dim[0]) begin run++; tick(1); end
    gap = run;
    while (!dim[0]) begin gap++; tick(1); end
    chk(run, 128, "R8 high run");
    chk(gap, 256, "R8 period length");
  endtask

  task automatic t_glitch();
    int run;
    int bad;
    int last;
    bit started;
    send_bits(frame(8'h10, 8'h09, 8'hA0, 8'hFE), 32, 1'b0);
    pulse_eof();
    bad = 0; last = 0; run = 0; started = 0;
    for (int c = 0; c < 1200; c++) begin
      if (dim[0]) begin
        run++;
      end else if (run > 0) begin
        if (started && run != 16 && run != 128) bad++;
        if (started) last = run;
        run = 0;
      end
      if (!dim[0]) started = 1;
      tick(1);
    end
    chk(bad, 0, "R9 partial pulses");
    chk(last, 16, "R9 new duty applied");
  endtask

  initial begin
    tick(5);
    t_reset();
    t_order();
    t_floor();
    t_edge();
    t_hold();
    t_badlen();
    t_period();
    t_glitch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule